// File: doc/BRIEF.md
# Device-Side Ultra DMA Write Burst Terminator

This block sits on the device end of an Ultra DMA write (data-out) transfer and handles the end of a burst when the device itself wants it to stop. The host clocks data words onto the 16-bit bus by toggling its strobe. Every transition of the strobe, rising or falling, carries one word. The block samples the strobe, STOP and DMACK- through two-flop synchronisers on the system clock. It reports each accepted word with a one-cycle pulse.

When the device's buffer logic asks for a stop, the block first makes sure the burst has moved at least one word. It then pauses by raising its ready line. It accepts a bounded number of trailing words that were already in flight. It holds its DMA request for a programmable minimum number of cycles, and then drops the request. After that it ignores the host's final, data-less strobe assertion.

When the host releases DMACK- with STOP raised, the block latches the host's CRC word from the bus and compares it with the device's own running CRC. It then stops driving its ready line and pulses burst-done. A sticky error flag, together with the host CRC value that first failed, is kept across all bursts until the next command starts.

Top module: `dout_burst_term`

## Requirements
- R1: After reset, dma_req is 1, ready_oe is 0, burst_done is 0 and crc_err is 0.
- R2: A low host_ack_n starts a burst: ready_oe goes to 1 and ready_n goes to 0. Every transition of host_strobe, in either direction, produces exactly one word_valid pulse while the burst is running.
- R3: stop_req has no effect until at least one word of the current burst has been accepted. Before that, ready_n stays 0.
- R4: On an accepted stop_req, ready_n goes to 1. Trailing strobe transitions are then accepted as words up to a limit. The limit is one word if the last data transition came less than SR_CYC cycles before the stop was taken, and two words otherwise. Further transitions give no word_valid.
- R5: dma_req stays 1 for at least RP_CYC cycles after ready_n goes to 1. It then goes to 0 and stays 0 until the burst has ended.
- R6: Once dma_req is 0, strobe transitions produce no word_valid pulse.
- R7: When host_ack_n rises while host_stop is 1 after dma_req has dropped, host_crc takes the value on host_data and burst_done pulses for one cycle.
- R8: ready_oe is 0 from the cycle after the CRC capture.
- R9: A capture whose host CRC differs from dev_crc sets crc_err and records that host CRC in first_bad_crc. While crc_err is set, later captures, whether they match or miscompare, change neither output.
- R10: cmd_start clears crc_err and first_bad_crc to 0. If cmd_start coincides with a capture, the result of that capture is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start of a new command; clears the error record |
| stop_req | input | 1 | Buffer logic asks to end the current burst |
| dev_crc | input | 16 | Device's own running CRC value |
| host_strobe | input | 1 | Host data strobe (asynchronous) |
| host_stop | input | 1 | Host STOP line (asynchronous) |
| host_ack_n | input | 1 | Host DMA acknowledge, active low (asynchronous) |
| host_data | input | 16 | Host data bus |
| ready_n | output | 1 | Device ready, active low |
| ready_oe | output | 1 | Drive enable of ready_n; 0 means released |
| dma_req | output | 1 | Device DMA request |
| word_valid | output | 1 | One-cycle pulse per accepted data word |
| host_crc | output | 16 | Host CRC latched at the last capture |
| burst_done | output | 1 | One-cycle pulse when a burst has ended |
| crc_err | output | 1 | Sticky CRC miscompare flag for the command |
| first_bad_crc | output | 16 | Host CRC of the first miscompare of the command |

## Verification
The clear of the error record by cmd_start and the recording of a miscompare can both fall on the same clock edge. The bench provokes this by releasing host_ack_n and placing cmd_start exactly on the edge where the synchronised acknowledge rise is taken, which is the third edge after the release. It judges the result by expecting crc_err to stay 1 with the new burst's host CRC in first_bad_crc. A second, lone cmd_start must then clear both. The trailing-word limit is judged by counting word_valid pulses when three trailing transitions are offered after a stop taken close to, and far from, the last data transition.

// File: rtl/dterm_pkg.sv
// Shared types for the write-burst terminator.
package dterm_pkg;
    // Controller phases of one device-terminated write burst.
    typedef enum logic [2:0] {
        S_IDLE,
        S_XFER,
        S_PAUSE,
        S_DRAIN,
        S_WAIT_ACK,
        S_DONE
    } term_state_t;
endpackage

// File: rtl/dterm_sync.sv
// Multi-bit synchroniser with one extra history flop per bit.
// Assumes each input bit is an independent level; sync_o is the
// synchronised value, prev_o the value one cycle earlier, so edges
// are sync_o ^ prev_o. RST_VAL sets the idle level of each bit.
module dterm_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES:0] sh;
        // Shift the raw input through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= {(STAGES+1){RST_VAL[b]}};
            else        sh <= {sh[STAGES-1:0], async_i[b]};
        end
        assign sync_o[b] = sh[STAGES-1];
        assign prev_o[b] = sh[STAGES];
    end
endmodule

// File: rtl/dterm_ctrl.sv
// Termination state machine. Accepts words on strobe edges, pauses on a
// stop request once a word has moved, admits a bounded number of
// trailing words, holds the DMA request for RP_CYC cycles, then waits
// for the host to release the acknowledge with STOP raised.
// Assumes synchronised inputs and RP_CYC >= 2.
module dterm_ctrl
    import dterm_pkg::*;
#(
    parameter int SR_CYC = 4,
    parameter int RP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_edge,
    input  logic stop_s,
    input  logic ack_s,
    input  logic ack_rise,
    input  logic stop_req,
    output logic word_valid,
    output logic ready_n,
    output logic ready_oe,
    output logic dma_req,
    output logic capture,
    output logic burst_done
);
    localparam int SW = $clog2(SR_CYC + 1);
    localparam int CW = $clog2(RP_CYC + 1);

    term_state_t state, state_nx;
    logic          word_seen;
    logic [SW-1:0] since_edge;
    logic [CW-1:0] rp_cnt;
    logic [1:0]    trail_cnt;
    logic [1:0]    allow;
    logic          trailing;

    assign trailing   = (state == S_PAUSE) || (state == S_DRAIN);
    assign word_valid = stb_edge && ((state == S_XFER) || (trailing && trail_cnt < allow));
    assign capture    = (state == S_WAIT_ACK) && ack_rise && stop_s;
    assign ready_oe   = (state != S_IDLE) && (state != S_DONE);
    assign ready_n    = (state != S_XFER);
    assign dma_req    = (state == S_IDLE) || (state == S_XFER) || trailing;
    assign burst_done = (state == S_DONE);

    // Next-state selection for the burst phases.
    always_comb begin
        state_nx = state;
        case (state)
            S_IDLE:     if (!ack_s) state_nx = S_XFER;
            S_XFER:     if (stop_req && (word_seen || stb_edge)) state_nx = S_PAUSE;
            S_PAUSE:    state_nx = S_DRAIN;
            S_DRAIN:    if (rp_cnt >= CW'(RP_CYC - 1)) state_nx = S_WAIT_ACK;
            S_WAIT_ACK: if (capture) state_nx = S_DONE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Cycles since the last strobe edge, saturating at SR_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                      since_edge <= SW'(SR_CYC);
        else if (stb_edge)               since_edge <= '0;
        else if (since_edge < SW'(SR_CYC)) since_edge <= since_edge + 1'b1;
    end

    // Word-seen flag, trailing allowance, trailing count and pause timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_seen <= 1'b0;
            rp_cnt    <= '0;
            trail_cnt <= '0;
            allow     <= 2'd2;
        end else begin
            if (state == S_IDLE) word_seen <= 1'b0;
            if (state == S_XFER && word_valid) word_seen <= 1'b1;
            if (state == S_XFER && state_nx == S_PAUSE) begin
                allow     <= (stb_edge || since_edge < SW'(SR_CYC)) ? 2'd1 : 2'd2;
                trail_cnt <= '0;
                rp_cnt    <= '0;
            end else if (trailing) begin
                if (rp_cnt < CW'(RP_CYC)) rp_cnt <= rp_cnt + 1'b1;
                if (word_valid) trail_cnt <= trail_cnt + 1'b1;
            end
        end
    end

    // Checker counter: cycles with ready paused while the request is held.
    logic [CW:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_XFER) hi_cnt <= '0;
        else if (ready_oe && ready_n && dma_req && hi_cnt < (CW+1)'(RP_CYC))
            hi_cnt <= hi_cnt + 1'b1;
    end

    // R3: the pause only follows an accepted word.
    p_word_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(word_seen || word_valid));
    // R4: trailing words never exceed the allowance.
    p_trail_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trailing |-> trail_cnt <= allow);
    // R5: request held for RP_CYC paused cycles before it drops.
    p_rp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> hi_cnt >= (CW+1)'(RP_CYC));
    // R6: no words once the request is down inside a burst.
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_oe && !dma_req) |-> !word_valid);
    // R8: ready line released right after capture.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !ready_oe);
endmodule

// File: rtl/dterm_crc.sv
// Host CRC capture and first-error record for one command.
// Latches the host CRC on each capture, compares it with the device CRC
// and keeps only the first miscompare until cmd_start. A capture in the
// same cycle as cmd_start belongs to the new command.
module dterm_crc #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          capture,
    input  logic [DW-1:0] host_data,
    input  logic [DW-1:0] dev_crc,
    output logic [DW-1:0] host_crc,
    output logic          crc_err,
    output logic [DW-1:0] first_bad
);
    logic mismatch;
    assign mismatch = capture && (host_data != dev_crc);

    // Latch the host's CRC word on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_crc <= '0;
        else if (capture) host_crc <= host_data;
    end

    // Sticky first-error record, cleared by a command start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err   <= 1'b0;
            first_bad <= '0;
        end else if (cmd_start) begin
            crc_err   <= mismatch;
            first_bad <= mismatch ? host_data : '0;
        end else if (mismatch && !crc_err) begin
            crc_err   <= 1'b1;
            first_bad <= host_data;
        end
    end

    // R7: captured word equals the bus value at capture.
    p_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> host_crc == $past(host_data));
    // R9: first error is kept until a new command.
    p_keep_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !cmd_start) |=> (crc_err && $stable(first_bad)));
endmodule

// File: rtl/dout_burst_term.sv
// Top of the device-side write-burst terminator. Synchronises the host
// strobe, STOP and acknowledge, runs the termination controller and the
// CRC check. Assumes host_data is stable around the acknowledge release.
module dout_burst_term #(
    parameter int DW     = 16,
    parameter int SR_CYC = 4,
    parameter int RP_CYC = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          stop_req,
    input  logic [DW-1:0] dev_crc,
    input  logic          host_strobe,
    input  logic          host_stop,
    input  logic          host_ack_n,
    input  logic [DW-1:0] host_data,
    output logic          ready_n,
    output logic          ready_oe,
    output logic          dma_req,
    output logic          word_valid,
    output logic [DW-1:0] host_crc,
    output logic          burst_done,
    output logic          crc_err,
    output logic [DW-1:0] first_bad_crc
);
    localparam int BIT_STB = 0;
    localparam int BIT_STP = 1;
    localparam int BIT_ACK = 2;

    logic [2:0] sync_v, prev_v;
    logic       capture;

    dterm_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_ack_n, host_stop, host_strobe}),
        .sync_o  (sync_v),
        .prev_o  (prev_v)
    );

    dterm_ctrl #(.SR_CYC(SR_CYC), .RP_CYC(RP_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_edge   (sync_v[BIT_STB] ^ prev_v[BIT_STB]),
        .stop_s     (sync_v[BIT_STP]),
        .ack_s      (sync_v[BIT_ACK]),
        .ack_rise   (sync_v[BIT_ACK] & ~prev_v[BIT_ACK]),
        .stop_req   (stop_req),
        .word_valid (word_valid),
        .ready_n    (ready_n),
        .ready_oe   (ready_oe),
        .dma_req    (dma_req),
        .capture    (capture),
        .burst_done (burst_done)
    );

    dterm_crc #(.DW(DW)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .capture   (capture),
        .host_data (host_data),
        .dev_crc   (dev_crc),
        .host_crc  (host_crc),
        .crc_err   (crc_err),
        .first_bad (first_bad_crc)
    );

    // R7: done pulse lasts a single cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);
endmodule

// File: tb/dout_burst_term_test.sv
`timescale 1ns/1ps
module dout_burst_term_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic        stop_req = 1'b0;
    logic [15:0] dev_crc = '0;
    logic        host_strobe = 1'b1;
    logic        host_stop = 1'b0;
    logic        host_ack_n = 1'b1;
    logic [15:0] host_data = '0;
    logic        ready_n, ready_oe, dma_req, word_valid, burst_done, crc_err;
    logic [15:0] host_crc, first_bad_crc;

    int errors = 0;
    int checks = 0;
    int wv_cnt = 0;
    int done_cnt = 0;
    int hi_cnt = 0;

    always #5 clk = ~clk;

    dout_burst_term #(.DW(16), .SR_CYC(4), .RP_CYC(8), .STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .stop_req(stop_req),
        .dev_crc(dev_crc), .host_strobe(host_strobe), .host_stop(host_stop),
        .host_ack_n(host_ack_n), .host_data(host_data), .ready_n(ready_n),
        .ready_oe(ready_oe), .dma_req(dma_req), .word_valid(word_valid),
        .host_crc(host_crc), .burst_done(burst_done), .crc_err(crc_err),
        .first_bad_crc(first_bad_crc)
    );

    // Output monitors sampled between edges.
    always @(negedge clk) begin
        if (word_valid) wv_cnt++;
        if (burst_done) done_cnt++;
        if (ready_oe && ready_n && dma_req) hi_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start_burst();
        @(negedge clk);
        wv_cnt = 0; hi_cnt = 0; done_cnt = 0;
        host_ack_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic word(input int gap);
        host_strobe = ~host_strobe;
        repeat (gap) @(negedge clk);
    endtask

    // Wait for the request to drop, raise STOP, finish with CRC.
    task automatic finish(input logic [15:0] hval, input bit coincide);
        int n = 0;
        while (dma_req && n < 100) begin @(negedge clk); n++; end
        check(!dma_req, "R5 request dropped", dma_req, 0);
        check(hi_cnt >= 8, "R5 hold cycles", hi_cnt, 8);
        host_stop = 1'b1;
        if (!host_strobe) host_strobe = 1'b1;
        host_data = hval;
        repeat (5) @(negedge clk);
        check(!dma_req, "R5 request stays low", dma_req, 0);
        host_ack_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cmd_start = coincide;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        stop_req = 1'b0;
        host_stop = 1'b0;
        check(host_crc == hval, "R7 host crc", host_crc, hval);
        check(done_cnt == 1, "R7 done pulse", done_cnt, 1);
        check(!ready_oe, "R8 ready released", ready_oe, 0);
    endtask

    task automatic t_reset();
        check(dma_req == 1'b1, "R1 dma_req", dma_req, 1);
        check(ready_oe == 1'b0, "R1 ready_oe", ready_oe, 0);
        check(burst_done == 1'b0, "R1 burst_done", burst_done, 0);
        check(crc_err == 1'b0, "R1 crc_err", crc_err, 0);
    endtask

    task automatic t_early_stop();
        int w;
        start_burst();
        check(ready_oe && !ready_n, "R2 burst ready", {ready_oe, ready_n}, 2);
        stop_req = 1'b1;
        repeat (6) @(negedge clk);
        check(!ready_n, "R3 stop ignored before word", ready_n, 0);
        word(6);
        check(ready_n, "R3 stop taken after word", ready_n, 1);
        check(wv_cnt == 1, "R2 one word", wv_cnt, 1);
        w = wv_cnt;
        dev_crc = 16'h1111;
        finish(16'h1111, 1'b0);
        check(wv_cnt == w, "R6 final strobe ignored", wv_cnt, w);
        check(!crc_err, "R9 match keeps flag clear", crc_err, 0);
    endtask

    task automatic t_near();
        start_burst();
        word(6); word(6); word(3);
        stop_req = 1'b1;
        repeat (1) @(negedge clk);
        word(2); word(2); word(2);
        check(wv_cnt == 4, "R4 near stop one trailing", wv_cnt, 4);
        dev_crc = 16'h2222;
        finish(16'h2222, 1'b0);
    endtask

    task automatic t_far();
        int w;
        start_burst();
        word(6); word(10);
        stop_req = 1'b1;
        repeat (1) @(negedge clk);
        word(2); word(2); word(2);
        check(wv_cnt == 4, "R4 far stop two trailing", wv_cnt, 4);
        w = wv_cnt;
        dev_crc = 16'h3333;
        finish(16'h3333, 1'b0);
        check(wv_cnt == w, "R6 strobe after request drop", wv_cnt, w);
    endtask

    task automatic crc_burst(input logic [15:0] hval, input logic [15:0] dval, input bit coincide);
        start_burst();
        word(6);
        stop_req = 1'b1;
        dev_crc = dval;
        finish(hval, coincide);
    endtask

    task automatic t_first_error();
        crc_burst(16'hBEEF, 16'h1234, 1'b0);
        check(crc_err, "R9 miscompare sets flag", crc_err, 1);
        check(first_bad_crc == 16'hBEEF, "R9 first value", first_bad_crc, 16'hBEEF);
        crc_burst(16'hCAFE, 16'h0001, 1'b0);
        check(first_bad_crc == 16'hBEEF, "R9 second miscompare kept out", first_bad_crc, 16'hBEEF);
        crc_burst(16'h5555, 16'h5555, 1'b0);
        check(crc_err, "R9 match leaves flag", crc_err, 1);
    endtask

    task automatic t_clear();
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        check(!crc_err, "R10 clear flag", crc_err, 0);
        check(first_bad_crc == 16'h0, "R10 clear record", first_bad_crc, 0);
        crc_burst(16'hD00D, 16'h0F0F, 1'b1);
        check(crc_err, "R10 coincident capture kept", crc_err, 1);
        check(first_bad_crc == 16'hD00D, "R10 coincident value", first_bad_crc, 16'hD00D);
        @(negedge clk); cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        check(!crc_err, "R10 lone clear", crc_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_early_stop();
        t_near();
        t_far();
        t_first_error();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule